// File: doc/BRIEF.md
# Dual-Channel Disk Register Access Router

This block sits between a host I/O request channel and the register ports of up to four disk drives on two channels. Each accepted host request is matched against five address windows: the command and control windows of each channel, and one bus-master window. The block then forms the offset of the address inside the matched window. Task-file accesses go to exactly one of four drive ports. A write to a channel's select register also updates the device bit that the block keeps for that channel. Bus-master accesses go out on a separate port, tagged with the channel they belong to.

The host side has two valid/ready channels. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` is high only when no access is in flight, so a request held by the host simply waits. The response stays on `rsp_valid` with stable data and error until `rsp_ready` is sampled high. A response held back by the host therefore stalls the next request. Drive and bus-master ports are single-cycle strobes, and read data comes back in the same cycle as the strobe.

Sizes are coded on two bits: 0 is one byte, 1 is 16 bits, 2 is 32 bits, and 3 is invalid. The data register sits at offset 0 of a command window. The select register sits at offset 6, and its device bit is bit 4 of the written byte.

Top module: `ide_io_router`

## Requirements
- R1: Windows are checked in the order primary command, primary control, secondary command, secondary control, bus-master. The first window with base <= address < base+size wins, and the forwarded offset is the address minus that window's base.
- R2: An address that matches no window gives a response with `rsp_err`=1 and read data 0, and nothing is forwarded. This holds whether or not `io_en` is high.
- R3: While `io_en` is low, a request that matches a window strobes no drive port and no bus-master port and leaves both device bits unchanged. Its response has `rsp_err`=0 and read data 0.
- R4: A write to offset 6 of a command window, with `io_en` high, loads bit 4 of `req_wdata` into that channel's device bit. This happens whatever the size and whether or not the drive is present. The access is then handled against the newly selected drive. Both device bits are 0 after reset.
- R5: The target drive index is 2*channel + device bit, with channel 0 for primary and 1 for secondary. Exactly that bit of `drv_stb` is raised. `drv_ctrl` is 1 for a control window and 0 for a command window.
- R6: A 16-bit data-register access gives one strobe. A 32-bit one gives strobes on two consecutive cycles to the same drive and offset: first with the low half, then with the high half. Read data is {second read, first read}.
- R7: A byte access to the data register, a non-byte access to any other task-file register, and a size-3 bus-master access each give `rsp_err`=1, and nothing is strobed.
- R8: An access whose target drive has its `drv_present` bit low is dropped. No strobe is raised, the response has `rsp_err`=0 and read data 0, and the size is not checked.
- R9: A bus-master access raises `bm_stb` for one cycle with the window offset. `bm_chan` is 1 when the offset is 8 or more. A read returns `bm_rdata` as sampled in that cycle.
- R10: `req_ready` is low while a request is in flight. A response not yet taken keeps `rsp_valid`, `rsp_rdata` and `rsp_err` stable.
- R11: A byte read returns the drive's low byte, zero-extended. A byte write presents the written byte zero-extended on `drv_wdata`. Write responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decoding enable |
| drv_present | input | 4 | One bit per drive, high when the drive exists |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 invalid |
| req_addr | input | ADDR_W | Host I/O address |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_err | output | 1 | Decode or width error |
| rsp_rdata | output | 32 | Read data |
| drv_stb | output | 4 | One-hot drive access strobe |
| drv_write | output | 1 | Drive access direction |
| drv_ctrl | output | 1 | 1 for a control-window register |
| drv_off | output | OFF_W | Offset inside the window |
| drv_wdata | output | 16 | Drive write data |
| drv_rdata | input | 64 | Drive read data, 16 bits per drive, drive 0 lowest |
| bm_stb | output | 1 | Bus-master access strobe |
| bm_write | output | 1 | Bus-master access direction |
| bm_chan | output | 1 | Channel of the bus-master register |
| bm_size | output | 2 | Size code of the bus-master access |
| bm_off | output | OFF_W | Offset inside the bus-master window |
| bm_wdata | output | 32 | Bus-master write data |
| bm_rdata | input | 32 | Bus-master read data |

## Verification
The bench builds the router with windows that overlap on purpose. The primary control window starts at 0x1F6 with size 4, so its first two addresses fall inside the primary command window at 0x1F0. The bus-master window at 0x370 with size 16 has the secondary control window at 0x374 inside it. With these values, a single run shows priority resolving in both overlap regions. Addresses 0x1F8, 0x375, 0x372 and 0x37A then reach control offsets 2 and 1 and bus-master offsets on both channels. Drive 3 starts absent and is enabled later, so the same selected drive is seen first dropped and then served.

// File: rtl/ide_rt_pkg.sv
package ide_rt_pkg;
  localparam int NWIN   = 5;
  localparam int NCH    = 2;
  localparam int NDRV   = 2 * NCH;
  localparam int DRV_W  = 16;
  localparam int HOST_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

  // Window codes; numeric order is decode priority.
  typedef enum logic [2:0] {
    WIN_PCMD = 3'd0,
    WIN_PCTL = 3'd1,
    WIN_SCMD = 3'd2,
    WIN_SCTL = 3'd3,
    WIN_BM   = 3'd4,
    WIN_NONE = 3'd5
  } win_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ACC, ST_HI, ST_RSP
  } st_e;
endpackage

// File: rtl/ide_rt_decode.sv
module ide_rt_decode
  import ide_rt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter logic [NWIN*ADDR_W-1:0] BASES = '0,
  parameter logic [NWIN*ADDR_W-1:0] SIZES = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [OFF_W-1:0]  off
);
  logic [NWIN-1:0]   hit;
  logic [ADDR_W-1:0] rel [NWIN];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE_G = BASES[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] SIZE_G = SIZES[g*ADDR_W +: ADDR_W];
    assign rel[g] = addr - BASE_G;
    assign hit[g] = (addr >= BASE_G) && (rel[g] < SIZE_G);
  end

  // Lowest window index wins: scan from highest down.
  always_comb begin
    win = WIN_NONE;
    off = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win = win_e'(3'(i));
        off = rel[i][OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ide_rt_devsel.sv
module ide_rt_devsel
  import ide_rt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set_en,
  input  logic           set_ch,
  input  logic           set_val,
  output logic [NCH-1:0] dev_bit
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                       dev_bit[c] <= 1'b0;
      else if (set_en && set_ch == c[0]) dev_bit[c] <= set_val;
    end
  end
endmodule

// File: rtl/ide_rt_seq.sv
module ide_rt_seq
  import ide_rt_pkg::*;
#(
  parameter int OFF_W    = 4,
  parameter int DATA_OFF = 0,
  parameter int SEL_OFF  = 6,
  parameter int DEV_BIT  = 4,
  parameter int BM_SPLIT = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_en,
  input  logic [NDRV-1:0]       drv_present,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [HOST_W-1:0]     req_wdata,
  input  win_e                  dec_win,
  input  logic [OFF_W-1:0]      dec_off,
  input  logic [NCH-1:0]        dev_bit,
  output logic                  lat_en,
  output logic                  lat_ch,
  output logic                  lat_val,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_err,
  output logic [HOST_W-1:0]     rsp_rdata,
  output logic [NDRV-1:0]       drv_stb,
  output logic                  drv_write,
  output logic                  drv_ctrl,
  output logic [OFF_W-1:0]      drv_off,
  output logic [DRV_W-1:0]      drv_wdata,
  input  logic [NDRV*DRV_W-1:0] drv_rdata,
  output logic                  bm_stb,
  output logic                  bm_write,
  output logic                  bm_chan,
  output logic [1:0]            bm_size,
  output logic [OFF_W-1:0]      bm_off,
  output logic [HOST_W-1:0]     bm_wdata,
  input  logic [HOST_W-1:0]     bm_rdata
);
  st_e                st;
  win_e               r_win;
  logic [OFF_W-1:0]   r_off;
  logic               r_write;
  logic [1:0]         r_size;
  logic [HOST_W-1:0]  r_wdata;
  logic [1:0]         r_idx;
  logic [HOST_W-1:0]  r_rdata;
  logic               r_err;

  logic is_miss, is_bm, is_tf, is_cmd, ch, sel_wr, dbit, present;
  logic is_data, size_ok, fwd_drv, fwd_bm, split, acc_err;
  logic [1:0]       idx, rd_idx;
  logic [DRV_W-1:0] cur_rd;

  always_comb begin
    is_miss = (r_win == WIN_NONE);
    is_bm   = (r_win == WIN_BM);
    is_tf   = !is_miss && !is_bm;
    is_cmd  = (r_win == WIN_PCMD) || (r_win == WIN_SCMD);
    ch      = is_bm ? (r_off >= OFF_W'(BM_SPLIT))
                    : ((r_win == WIN_SCMD) || (r_win == WIN_SCTL));
    sel_wr  = (st == ST_ACC) && io_en && is_cmd && r_write
              && (r_off == OFF_W'(SEL_OFF));
    dbit    = sel_wr ? r_wdata[DEV_BIT] : dev_bit[ch];
    idx     = {ch, dbit};
    present = drv_present[idx];
    is_data = is_cmd && (r_off == OFF_W'(DATA_OFF));
    size_ok = is_data ? (r_size == SZ_HALF || r_size == SZ_WORD)
                      : (r_size == SZ_BYTE);
    fwd_drv = (st == ST_ACC) && io_en && is_tf && present && size_ok;
    fwd_bm  = (st == ST_ACC) && io_en && is_bm && (r_size != SZ_BAD);
    split   = fwd_drv && is_data && (r_size == SZ_WORD);
    acc_err = is_miss || (io_en && is_bm && r_size == SZ_BAD)
              || (io_en && is_tf && present && !size_ok);
    rd_idx  = (st == ST_HI) ? r_idx : idx;
    cur_rd  = drv_rdata[{rd_idx, 4'b0000} +: DRV_W];
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RSP);
  assign rsp_err   = r_err;
  assign rsp_rdata = r_rdata;

  assign drv_stb   = fwd_drv ? (NDRV'(1) << idx)
                   : ((st == ST_HI) ? (NDRV'(1) << r_idx) : '0);
  assign drv_write = r_write;
  assign drv_ctrl  = (r_win == WIN_PCTL) || (r_win == WIN_SCTL);
  assign drv_off   = r_off;
  assign drv_wdata = (st == ST_HI) ? r_wdata[31:16]
                   : ((r_size == SZ_BYTE) ? {8'h00, r_wdata[7:0]} : r_wdata[15:0]);

  assign bm_stb    = fwd_bm;
  assign bm_write  = r_write;
  assign bm_chan   = ch;
  assign bm_size   = r_size;
  assign bm_off    = r_off;
  assign bm_wdata  = r_wdata;

  assign lat_en    = sel_wr;
  assign lat_ch    = ch;
  assign lat_val   = r_wdata[DEV_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      r_win   <= WIN_NONE;
      r_off   <= '0;
      r_write <= 1'b0;
      r_size  <= SZ_BYTE;
      r_wdata <= '0;
      r_idx   <= '0;
      r_rdata <= '0;
      r_err   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st      <= ST_ACC;
          r_win   <= dec_win;
          r_off   <= dec_off;
          r_write <= req_write;
          r_size  <= req_size;
          r_wdata <= req_wdata;
        end
        ST_ACC: begin
          r_err   <= acc_err;
          r_idx   <= idx;
          r_rdata <= '0;
          if (fwd_drv && !r_write)
            r_rdata <= (r_size == SZ_BYTE) ? {24'h0, cur_rd[7:0]} : {16'h0, cur_rd};
          if (fwd_bm && !r_write)
            r_rdata <= bm_rdata;
          st <= split ? ST_HI : ST_RSP;
        end
        ST_HI: begin
          if (!r_write) r_rdata[31:16] <= cur_rd;
          st <= ST_RSP;
        end
        ST_RSP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ide_io_router.sv
module ide_io_router
  import ide_rt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int PCMD_BASE = 'h01F0,
  parameter int PCMD_SIZE = 8,
  parameter int PCTL_BASE = 'h03F4,
  parameter int PCTL_SIZE = 4,
  parameter int SCMD_BASE = 'h0170,
  parameter int SCMD_SIZE = 8,
  parameter int SCTL_BASE = 'h0374,
  parameter int SCTL_SIZE = 4,
  parameter int BM_BASE   = 'hC000,
  parameter int BM_SIZE   = 16,
  parameter int DATA_OFF  = 0,
  parameter int SEL_OFF   = 6,
  parameter int DEV_BIT   = 4,
  parameter int BM_SPLIT  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_en,
  input  logic [NDRV-1:0]       drv_present,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [HOST_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_err,
  output logic [HOST_W-1:0]     rsp_rdata,
  output logic [NDRV-1:0]       drv_stb,
  output logic                  drv_write,
  output logic                  drv_ctrl,
  output logic [OFF_W-1:0]      drv_off,
  output logic [DRV_W-1:0]      drv_wdata,
  input  logic [NDRV*DRV_W-1:0] drv_rdata,
  output logic                  bm_stb,
  output logic                  bm_write,
  output logic                  bm_chan,
  output logic [1:0]            bm_size,
  output logic [OFF_W-1:0]      bm_off,
  output logic [HOST_W-1:0]     bm_wdata,
  input  logic [HOST_W-1:0]     bm_rdata
);
  localparam logic [NWIN*ADDR_W-1:0] BASES = {ADDR_W'(BM_BASE), ADDR_W'(SCTL_BASE),
    ADDR_W'(SCMD_BASE), ADDR_W'(PCTL_BASE), ADDR_W'(PCMD_BASE)};
  localparam logic [NWIN*ADDR_W-1:0] SIZES = {ADDR_W'(BM_SIZE), ADDR_W'(SCTL_SIZE),
    ADDR_W'(SCMD_SIZE), ADDR_W'(PCTL_SIZE), ADDR_W'(PCMD_SIZE)};

  win_e             dec_win;
  logic [OFF_W-1:0] dec_off;
  logic [NCH-1:0]   dev_bit;
  logic             lat_en, lat_ch, lat_val;

  ide_rt_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASES(BASES), .SIZES(SIZES)) u_dec (
    .addr(req_addr), .win(dec_win), .off(dec_off)
  );

  ide_rt_devsel u_sel (
    .clk(clk), .rst_n(rst_n), .set_en(lat_en), .set_ch(lat_ch),
    .set_val(lat_val), .dev_bit(dev_bit)
  );

  ide_rt_seq #(.OFF_W(OFF_W), .DATA_OFF(DATA_OFF), .SEL_OFF(SEL_OFF),
               .DEV_BIT(DEV_BIT), .BM_SPLIT(BM_SPLIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .drv_present(drv_present),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_wdata(req_wdata),
    .dec_win(dec_win), .dec_off(dec_off), .dev_bit(dev_bit),
    .lat_en(lat_en), .lat_ch(lat_ch), .lat_val(lat_val),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .drv_stb(drv_stb), .drv_write(drv_write), .drv_ctrl(drv_ctrl), .drv_off(drv_off),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .bm_stb(bm_stb), .bm_write(bm_write), .bm_chan(bm_chan), .bm_size(bm_size),
    .bm_off(bm_off), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata)
  );
endmodule

// File: rtl/ide_rt_chk.sv
module ide_rt_chk
  import ide_rt_pkg::*;
#(
  parameter int OFF_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_en,
  input logic [NDRV-1:0]   drv_present,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [HOST_W-1:0] rsp_rdata,
  input logic [NDRV-1:0]   drv_stb,
  input logic [OFF_W-1:0]  drv_off,
  input logic              bm_stb
);
  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_stb)); // R5

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bm_stb && (|drv_stb))); // R1

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|drv_stb) && !$past(|drv_stb)) |-> io_en); // R3

  AST_OFF_NO_BM: assert property (@(posedge clk) disable iff (!rst_n)
    bm_stb |-> io_en); // R3

  AST_ABSENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|drv_stb) && !$past(|drv_stb)) |-> ((drv_stb & ~drv_present) == '0)); // R8

  AST_SPLIT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    ((|drv_stb) && $past(|drv_stb)) |-> (drv_stb == $past(drv_stb) && drv_off == $past(drv_off))); // R6

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R10
endmodule

bind ide_io_router ide_rt_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_en(io_en), .drv_present(drv_present),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .drv_stb(drv_stb),
  .drv_off(drv_off), .bm_stb(bm_stb)
);

// File: tb/ide_io_router_tb.sv
`timescale 1ns/1ps
module ide_io_router_tb;
  localparam int AW = 16;
  localparam int OW = 4;
  localparam int unsigned WB [5] = '{'h1F0, 'h1F6, 'h170, 'h374, 'h370};
  localparam int unsigned WS [5] = '{8, 4, 8, 4, 16};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, io_en = 1'b1;
  logic [3:0]  present = 4'b0111;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  drv_stb;
  logic        drv_write, drv_ctrl;
  logic [OW-1:0] drv_off;
  logic [15:0] drv_wdata;
  logic [63:0] drv_rdata;
  logic        bm_stb, bm_write, bm_chan;
  logic [1:0]  bm_size;
  logic [OW-1:0] bm_off;
  logic [31:0] bm_wdata, bm_rdata;

  ide_io_router #(
    .ADDR_W(AW), .OFF_W(OW),
    .PCMD_BASE('h1F0), .PCMD_SIZE(8), .PCTL_BASE('h1F6), .PCTL_SIZE(4),
    .SCMD_BASE('h170), .SCMD_SIZE(8), .SCTL_BASE('h374), .SCTL_SIZE(4),
    .BM_BASE('h370), .BM_SIZE(16)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .drv_present(present),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .drv_stb(drv_stb), .drv_write(drv_write), .drv_ctrl(drv_ctrl), .drv_off(drv_off),
    .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
    .bm_stb(bm_stb), .bm_write(bm_write), .bm_chan(bm_chan), .bm_size(bm_size),
    .bm_off(bm_off), .bm_wdata(bm_wdata), .bm_rdata(bm_rdata)
  );

  // Drive models: read data = {drive+1, 0, reads served so far}.
  logic [7:0] dcnt [4];
  for (genvar i = 0; i < 4; i++) begin : g_drv
    assign drv_rdata[i*16 +: 16] = {4'(i + 1), 4'h0, dcnt[i]};
    always @(posedge clk) begin
      if (!rst_n) dcnt[i] <= 8'h00;
      else if (drv_stb[i] && !drv_write) dcnt[i] <= dcnt[i] + 8'h01;
    end
  end
  assign bm_rdata = {16'hB0B0, 12'h000, bm_off};

  int n_vec = 0, n_bad = 0;
  int m_cnt [4] = '{0, 0, 0, 0};
  bit m_dev [2] = '{1'b0, 1'b0};

  bit          e_err, e_bm, e_bmch, e_ctrl;
  logic [31:0] e_rd;
  int          e_ns;
  logic [3:0]  e_stb;
  logic [3:0]  e_off;
  logic [15:0] e_wd [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] addr, input bit wr, input logic [1:0] sz,
                       input logic [31:0] wd);
    int w = 5;
    int unsigned off = 0;
    bit ch, cmd, data, ok;
    int d;
    logic [15:0] lo;
    for (int i = 4; i >= 0; i--)
      if (addr >= WB[i] && addr < WB[i] + WS[i]) begin w = i; off = addr - WB[i]; end
    e_err = 0; e_rd = '0; e_ns = 0; e_bm = 0; e_bmch = 0; e_stb = '0;
    e_off = 4'(off); e_ctrl = (w == 1 || w == 3);
    e_wd[0] = (sz == 2'd0) ? {8'h00, wd[7:0]} : wd[15:0];
    e_wd[1] = wd[31:16];
    if (w == 5) begin e_err = 1; return; end
    if (!io_en) return;
    if (w == 4) begin
      e_bmch = (off >= 8);
      if (sz == 2'd3) e_err = 1;
      else begin
        e_bm = 1;
        if (!wr) e_rd = {16'hB0B0, 12'h000, 4'(off)};
      end
      return;
    end
    ch  = (w >= 2);
    cmd = (w == 0 || w == 2);
    if (cmd && wr && off == 6) m_dev[ch] = wd[4];
    d = (ch ? 2 : 0) + (m_dev[ch] ? 1 : 0);
    if (!present[d]) return;
    data = cmd && off == 0;
    ok   = data ? (sz == 2'd1 || sz == 2'd2) : (sz == 2'd0);
    if (!ok) begin e_err = 1; return; end
    e_ns  = (data && sz == 2'd2) ? 2 : 1;
    e_stb = 4'(1 << d);
    if (!wr) begin
      lo = {4'(d + 1), 4'h0, 8'(m_cnt[d])};
      e_rd = (sz == 2'd0) ? {24'h0, lo[7:0]} : {16'h0, lo};
      m_cnt[d]++;
      if (e_ns == 2) begin
        e_rd[31:16] = {4'(d + 1), 4'h0, 8'(m_cnt[d])};
        m_cnt[d]++;
      end
    end
  endtask

  task automatic xfer(input string tag, input logic [15:0] addr, input bit wr,
                      input logic [1:0] sz, input logic [31:0] wd, input int hold);
    @(negedge clk);
    chk({tag, " R10 ready when idle"}, {31'h0, req_ready}, 32'h1);
    model(addr, wr, sz, wd);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 busy"}, {31'h0, req_ready}, 32'h0);
    chk({tag, " R5 strobe"}, {28'h0, drv_stb}, {28'h0, e_ns > 0 ? e_stb : 4'h0});
    if (e_ns > 0) begin
      chk({tag, " R1 offset"}, {28'h0, drv_off}, {28'h0, e_off});
      chk({tag, " R5 ctrl"}, {31'h0, drv_ctrl}, {31'h0, e_ctrl});
      if (wr) chk({tag, " R11 wdata"}, {16'h0, drv_wdata}, {16'h0, e_wd[0]});
    end
    chk({tag, " R9 bm strobe"}, {31'h0, bm_stb}, {31'h0, e_bm});
    if (e_bm) begin
      chk({tag, " R9 bm chan"}, {31'h0, bm_chan}, {31'h0, e_bmch});
      chk({tag, " R9 bm offset"}, {28'h0, bm_off}, {28'h0, e_off});
    end
    chk({tag, " R10 no early rsp"}, {31'h0, rsp_valid}, 32'h0);
    if (e_ns == 2) begin
      @(negedge clk);
      chk({tag, " R6 high strobe"}, {28'h0, drv_stb}, {28'h0, e_stb});
      if (wr) chk({tag, " R6 high wdata"}, {16'h0, drv_wdata}, {16'h0, e_wd[1]});
      chk({tag, " R6 no early rsp"}, {31'h0, rsp_valid}, 32'h0);
    end
    @(negedge clk);
    chk({tag, " R10 rsp valid"}, {31'h0, rsp_valid}, 32'h1);
    chk({tag, " R2 err"}, {31'h0, rsp_err}, {31'h0, e_err});
    chk({tag, " R6 rdata"}, rsp_rdata, e_rd);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk({tag, " R10 held valid"}, {31'h0, rsp_valid}, 32'h1);
      chk({tag, " R10 held data"}, rsp_rdata, e_rd);
      chk({tag, " R5 no strobe while held"}, {28'h0, drv_stb}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R10 rsp taken"}, {31'h0, rsp_valid}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R5 reset strobes", {27'h0, bm_stb, drv_stb}, 32'h0);
    rst_n = 1'b1;
    xfer("R11 byte read drive0",      16'h1F1, 0, 2'd0, 32'h0, 0);
    xfer("R6 half read",              16'h1F0, 0, 2'd1, 32'h0, 0);
    xfer("R6 split read",             16'h1F0, 0, 2'd2, 32'h0, 0);
    xfer("R6 split write",            16'h1F0, 1, 2'd2, 32'hCAFE_1234, 0);
    xfer("R4 select dev1 primary",    16'h1F6, 1, 2'd0, 32'h0000_0010, 0);
    xfer("R4 read uses drive1",       16'h1F7, 0, 2'd0, 32'h0, 2);
    xfer("R7 byte on data reg",       16'h1F0, 0, 2'd0, 32'h0, 0);
    xfer("R7 half on status reg",     16'h1F2, 0, 2'd1, 32'h0, 0);
    xfer("R1 control after overlap",  16'h1F8, 1, 2'd0, 32'h0000_00A5, 0);
    xfer("R4 half select latches",    16'h1F6, 1, 2'd1, 32'h0000_0000, 0);
    xfer("R4 back on drive0",         16'h1F7, 0, 2'd0, 32'h0, 0);
    xfer("R5 secondary drive2",       16'h171, 0, 2'd0, 32'h0, 1);
    xfer("R8 select absent drive3",   16'h176, 1, 2'd0, 32'h0000_0010, 0);
    xfer("R8 absent split read",      16'h170, 0, 2'd2, 32'h0, 0);
    xfer("R8 absent bad width",       16'h171, 0, 2'd1, 32'h0, 0);
    present = 4'b1111;
    xfer("R5 drive3 split read",      16'h170, 0, 2'd2, 32'h0, 0);
    xfer("R1 sctl beats bm",          16'h375, 0, 2'd0, 32'h0, 0);
    xfer("R9 bm read chan0",          16'h372, 0, 2'd2, 32'h0, 0);
    xfer("R9 bm write chan1",         16'h37A, 1, 2'd2, 32'h1234_5678, 0);
    xfer("R7 bm bad size",            16'h373, 0, 2'd3, 32'h0, 0);
    xfer("R2 miss",                   16'h0100, 0, 2'd0, 32'h0, 0);
    io_en = 1'b0;
    xfer("R3 off read",               16'h1F1, 0, 2'd0, 32'h0, 0);
    xfer("R3 off select ignored",     16'h1F6, 1, 2'd0, 32'h0000_0010, 0);
    xfer("R3 off bm",                 16'h372, 0, 2'd2, 32'h0, 0);
    xfer("R2 miss while off",         16'h0100, 0, 2'd0, 32'h0, 0);
    io_en = 1'b1;
    xfer("R3 dev bit unchanged",      16'h1F7, 0, 2'd0, 32'h0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule